// File: doc/BRIEF.md
# Tile Video Processor Host Register Port

This block is the host-side register window of a tile-based video processor. A CPU reaches eight byte-wide registers through a one-cycle strobe with a 3-bit register index and a read/write flag. The block keeps the live video-memory pointer (`v`, 15 bits), a staging pointer (`t`, 15 bits) and a 3-bit horizontal fine-scroll value. Both pointers and the fine scroll are driven out for the renderer, together with the stored control and mask bytes.

Scroll and pointer writes are two-byte sequences that share one phase state machine with two states, `WR_FIRST` and `WR_SECOND`. A scroll or pointer write moves `WR_FIRST` to `WR_SECOND`, or `WR_SECOND` back to `WR_FIRST`. A status read forces `WR_FIRST` from either state. All other accesses leave the phase where it is. Both pointers share one bit layout, from bit 14 down: fine Y [14:12], page select [11:10], coarse Y [9:5], coarse X [4:0].

Data-port accesses go through the low 14 bits of `v`, and the external memory port answers in the same cycle. Each access then steps `v` by 1, or by one tile row (32), as the control byte selects. Reads normally return a one-deep buffer that the access refills. Reads in the colour-table page return the addressed byte directly.

Top module: `vid_reg_port`

## Requirements
- R1: After reset, the control byte, mask byte, vblank flag, read buffer, `v`, `t` and fine X are all zero, and the phase is `WR_FIRST`.
- R2: A write to index 0 stores the byte as the control byte and copies its bits [1:0] into `t[11:10]`. A write to index 1 stores the byte as the mask byte.
- R3: A write to index 5 in `WR_FIRST` puts bits [2:0] into fine X and bits [7:3] into `t[4:0]`. In `WR_SECOND` it puts bits [2:0] into `t[14:12]` and bits [7:3] into `t[9:5]`.
- R4: A write to index 6 in `WR_FIRST` sets `t[13:8]` to data bits [5:0] and clears `t[14]`. In `WR_SECOND` it sets `t[7:0]` to the byte and then copies the whole of `t` into `v`.
- R5: Every write to index 5 or 6 flips the phase. A read of index 2 returns it to `WR_FIRST`. No other access changes it.
- R6: A write to index 7 pulses `vram_we` with `vram_addr` equal to `v[13:0]` and `vram_wdata` equal to the byte. `v` then grows by 32 when control bit 2 is 1, and by 1 otherwise, modulo 2^15.
- R7: A read of index 7 outside the colour page returns the buffer in the same cycle. The buffer then takes `vram_rdata` at `v[13:0]`, and `v` steps as in R6.
- R8: A read of index 7 while `v[13:8]` is all ones returns `vram_rdata` directly. The buffer still refills and `v` still steps.
- R9: Index 2 reads return the vblank flag in bit 7 and zeros below it. The flag is set by `vblank_set`. An index 2 read clears it on the next edge, and the clear wins over a set in the same cycle.
- R10: Writes to indices 2, 3 and 4 change nothing. Reads of indices 0, 1, 3, 4, 5 and 6 return zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | One-cycle register access strobe |
| rd | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 3 | Register index |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the strobe cycle |
| vblank_set | input | 1 | Pulse that sets the vblank flag |
| vram_addr | output | 14 | Video-memory address (`v[13:0]`) |
| vram_we | output | 1 | Video-memory write enable |
| vram_re | output | 1 | Video-memory read strobe |
| vram_wdata | output | 8 | Video-memory write byte |
| vram_rdata | input | 8 | Video-memory read byte, same cycle |
| v_out | output | 15 | Live pointer to the renderer |
| t_out | output | 15 | Staging pointer to the renderer |
| fine_x | output | 3 | Horizontal fine scroll |
| ctrl_out | output | 8 | Stored control byte |
| mask_out | output | 8 | Stored mask byte |

## Verification
The bench uses the default parameters: fine width 3, coarse width 5, a 14-bit memory address and a row step of 32. With these values, pointer writes can reach the colour page at 0x3F00 and the row-step path can be told apart from the unit step. A pointer low byte of 0xFF followed by a unit step carries into the fine-Y bits, and bit 14 of `v` does not affect the colour-page test. The bench models video memory as a sparse map, so write-then-read sequences show the buffer lag.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_STAT    = 3'd2,
        SEL_SPR_ADR = 3'd3,
        SEL_SPR_DAT = 3'd4,
        SEL_SCROLL  = 3'd5,
        SEL_PTR     = 3'd6,
        SEL_DATA    = 3'd7
    } reg_sel_e;

    typedef enum logic {
        WR_FIRST  = 1'b0,
        WR_SECOND = 1'b1
    } wr_phase_e;

    typedef struct packed {
        logic ctrl_wr;
        logic mask_wr;
        logic scroll_wr;
        logic ptr_wr;
        logic data_wr;
        logic data_rd;
        logic stat_rd;
    } reg_hits_t;

endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
    import vrp_pkg::*;
(
    input  logic       cs,
    input  logic       rd,
    input  logic [2:0] sel,
    output reg_hits_t  hits
);

    reg_sel_e idx;
    assign idx = reg_sel_e'(sel);

    always_comb begin
        hits = '0;
        if (cs) begin
            unique case (idx)
                SEL_CTRL:    hits.ctrl_wr   = !rd;
                SEL_MASK:    hits.mask_wr   = !rd;
                SEL_STAT:    hits.stat_rd   = rd;
                SEL_SPR_ADR: hits          = '0;
                SEL_SPR_DAT: hits          = '0;
                SEL_SCROLL:  hits.scroll_wr = !rd;
                SEL_PTR:     hits.ptr_wr    = !rd;
                SEL_DATA: begin
                    hits.data_wr = !rd;
                    hits.data_rd = rd;
                end
            endcase
        end
    end

endmodule

// File: rtl/vrp_phase_fsm.sv
module vrp_phase_fsm
    import vrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip_ev,
    input  logic rewind_ev,
    output logic second
);

    wr_phase_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WR_FIRST;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_FIRST:  if (flip_ev) st_d = WR_SECOND;
            WR_SECOND: if (flip_ev || rewind_ev) st_d = WR_FIRST;
        endcase
    end

    always_comb begin
        second = (st_q == WR_SECOND);
    end

    assert_rewind_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_ev |=> !second);

    assert_flip_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip_ev |=> (second != $past(second)));

endmodule

// File: rtl/vrp_ptr_regs.sv
module vrp_ptr_regs #(
    parameter int FINE_W   = 3,
    parameter int COARSE_W = 5,
    parameter int VRAM_AW  = 14,
    parameter int ROW_STEP = 32,
    localparam int DATA_W  = FINE_W + COARSE_W,
    localparam int CY_LO   = COARSE_W,
    localparam int NT_LO   = 2 * COARSE_W,
    localparam int FY_LO   = NT_LO + 2,
    localparam int ADDR_W  = FY_LO + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              scroll_wr,
    input  logic              ptr_wr,
    input  logic              step_ev,
    input  logic              second,
    input  logic              row_step,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] v_q,
    output logic [ADDR_W-1:0] t_q,
    output logic [FINE_W-1:0] fx_q
);

    logic [ADDR_W-1:0] v_d, t_d;
    logic [FINE_W-1:0] fx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q  <= '0;
            t_q  <= '0;
            fx_q <= '0;
        end else begin
            v_q  <= v_d;
            t_q  <= t_d;
            fx_q <= fx_d;
        end
    end

    always_comb begin
        v_d  = v_q;
        t_d  = t_q;
        fx_d = fx_q;
        if (ctrl_wr) t_d[NT_LO +: 2] = wdata[1:0];
        if (scroll_wr) begin
            if (!second) begin
                fx_d                = wdata[FINE_W-1:0];
                t_d[COARSE_W-1:0]   = wdata[DATA_W-1:FINE_W];
            end else begin
                t_d[FY_LO +: FINE_W]   = wdata[FINE_W-1:0];
                t_d[CY_LO +: COARSE_W] = wdata[DATA_W-1:FINE_W];
            end
        end
        if (ptr_wr) begin
            if (!second) begin
                t_d[ADDR_W-1:DATA_W] = {{(ADDR_W-VRAM_AW){1'b0}},
                                        wdata[VRAM_AW-DATA_W-1:0]};
            end else begin
                t_d[DATA_W-1:0] = wdata;
                v_d             = t_d;
            end
        end
        if (step_ev) v_d = v_q + (row_step ? ADDR_W'(ROW_STEP) : ADDR_W'(1));
    end

    assert_ctrl_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (t_q[NT_LO +: 2] == $past(wdata[1:0])));

    assert_scroll_fine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_wr && !second) |=> (fx_q == $past(wdata[FINE_W-1:0])));

    assert_ptr_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && second) |=> (v_q == t_q));

    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ev && !row_step) |=> (v_q == $past(v_q) + ADDR_W'(1)));

endmodule

// File: rtl/vrp_read_path.sv
module vrp_read_path #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] stat_byte,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] buf_q;
    logic              pal;

    assign pal = &page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       buf_q <= '0;
        else if (data_rd) buf_q <= mem_rdata;
    end

    always_comb begin
        rdata = '0;
        if (stat_rd)      rdata = stat_byte;
        else if (data_rd) rdata = pal ? mem_rdata : buf_q;
    end

    assert_buffer_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !pal) ##1 (data_rd && !pal) |-> (rdata == $past(mem_rdata)));

    assert_palette_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && pal) |-> (rdata == mem_rdata));

endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
    import vrp_pkg::*;
#(
    parameter int FINE_W   = 3,
    parameter int COARSE_W = 5,
    parameter int VRAM_AW  = 14,
    parameter int ROW_STEP = 32,
    localparam int DATA_W  = FINE_W + COARSE_W,
    localparam int ADDR_W  = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               rd,
    input  logic [2:0]         reg_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               vblank_set,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               vram_we,
    output logic               vram_re,
    output logic [DATA_W-1:0]  vram_wdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic [ADDR_W-1:0]  v_out,
    output logic [ADDR_W-1:0]  t_out,
    output logic [FINE_W-1:0]  fine_x,
    output logic [DATA_W-1:0]  ctrl_out,
    output logic [DATA_W-1:0]  mask_out
);

    localparam int PAGE_W  = VRAM_AW - DATA_W;
    localparam int STEP_BIT = 2;

    reg_hits_t         hits;
    logic              second;
    logic              vblank_q;
    logic [DATA_W-1:0] ctrl_q, mask_q, stat_byte;

    vrp_decode u_dec (
        .cs   (cs),
        .rd   (rd),
        .sel  (reg_sel),
        .hits (hits)
    );

    vrp_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flip_ev   (hits.scroll_wr || hits.ptr_wr),
        .rewind_ev (hits.stat_rd),
        .second    (second)
    );

    vrp_ptr_regs #(
        .FINE_W   (FINE_W),
        .COARSE_W (COARSE_W),
        .VRAM_AW  (VRAM_AW),
        .ROW_STEP (ROW_STEP)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (hits.ctrl_wr),
        .scroll_wr (hits.scroll_wr),
        .ptr_wr    (hits.ptr_wr),
        .step_ev   (hits.data_wr || hits.data_rd),
        .second    (second),
        .row_step  (ctrl_q[STEP_BIT]),
        .wdata     (wdata),
        .v_q       (v_out),
        .t_q       (t_out),
        .fx_q      (fine_x)
    );

    vrp_read_path #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_rd   (hits.data_rd),
        .stat_rd   (hits.stat_rd),
        .page      (v_out[VRAM_AW-1:DATA_W]),
        .mem_rdata (vram_rdata),
        .stat_byte (stat_byte),
        .rdata     (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            mask_q   <= '0;
            vblank_q <= 1'b0;
        end else begin
            if (hits.ctrl_wr) ctrl_q <= wdata;
            if (hits.mask_wr) mask_q <= wdata;
            if (hits.stat_rd)   vblank_q <= 1'b0;
            else if (vblank_set) vblank_q <= 1'b1;
        end
    end

    assign stat_byte  = {vblank_q, {(DATA_W-1){1'b0}}};
    assign vram_addr  = v_out[VRAM_AW-1:0];
    assign vram_we    = hits.data_wr;
    assign vram_re    = hits.data_rd;
    assign vram_wdata = wdata;
    assign ctrl_out   = ctrl_q;
    assign mask_out   = mask_q;

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && reg_sel == 3'd2) |=> (rdata[DATA_W-1] == 1'b0 || !(cs && rd && reg_sel == 3'd2)));

    assert_set_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_set && !(cs && rd && reg_sel == 3'd2)) ##1 (cs && rd && reg_sel == 3'd2)
        |-> rdata[DATA_W-1]);

    assert_mem_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(vram_we && vram_re));

    assert_quiet_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && (reg_sel == 3'd3 || reg_sel == 3'd4)) |=> ($stable(v_out) && $stable(t_out)));

endmodule

// File: tb/sim_vid_reg_port.sv
module sim_vid_reg_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, vblank_set = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  wdata = '0, rdata, vram_wdata, vram_rdata, ctrl_out, mask_out;
    logic [13:0] vram_addr;
    logic        vram_we, vram_re;
    logic [14:0] v_out, t_out;
    logic [2:0]  fine_x;

    int tests = 0, fails = 0, cyc = 0, mem_gen = 0;
    bit done = 0;
    logic [7:0] mem [int];

    int m_ctrl, m_mask, m_vbl, m_buf, m_v, m_t, m_fx, m_tog;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .vblank_set(vblank_set),
        .vram_addr(vram_addr), .vram_we(vram_we), .vram_re(vram_re),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .v_out(v_out), .t_out(t_out), .fine_x(fine_x),
        .ctrl_out(ctrl_out), .mask_out(mask_out)
    );

    function automatic logic [7:0] lookup(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'((a * 13 + 5) ^ (a >> 8));
    endfunction

    always @(vram_addr or mem_gen) vram_rdata = lookup(int'(vram_addr));

    always @(posedge clk) begin
        if (vram_we) begin
            mem[int'(vram_addr)] = vram_wdata;
            mem_gen = mem_gen + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int sel, input bit r);
        case (sel)
            0: return r ? "R10" : "R2";
            1: return r ? "R10" : "R2";
            2: return r ? "R9" : "R10";
            5: return r ? "R10" : "R3";
            6: return r ? "R10" : "R4";
            7: return r ? "R7" : "R6";
            default: return "R10";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 v", int'(v_out), m_v);
            chk("R3 t", int'(t_out), m_t);
            chk("R3 fine_x", int'(fine_x), m_fx);
            chk("R2 ctrl", int'(ctrl_out), m_ctrl);
            chk("R2 mask", int'(mask_out), m_mask);
        end
    end

    task automatic op(input bit r, input int sel, input int d, input bit vb, input string req);
        int exp_rd, refill, old_v;
        @(negedge clk);
        cs = 1'b1; rd = r; reg_sel = sel[2:0]; wdata = d[7:0]; vblank_set = vb;
        #1;
        old_v  = m_v;
        refill = lookup(m_v & 'h3FFF);
        if (r) begin
            case (sel)
                2: exp_rd = m_vbl << 7;
                7: exp_rd = ((m_v & 'h3F00) == 'h3F00) ? refill : m_buf;
                default: exp_rd = 0;
            endcase
            chk(req, int'(rdata), exp_rd);
        end else if (sel == 7) begin
            chk(req, int'(vram_we), 1);
            chk(req, int'(vram_addr), m_v & 'h3FFF);
        end
        @(posedge clk); #1;
        cs = 1'b0; vblank_set = 1'b0;
        if (vb) m_vbl = 1;
        if (r) begin
            if (sel == 2) begin m_vbl = 0; m_tog = 0; end
            if (sel == 7) begin
                m_buf = refill;
                m_v = (m_v + ((m_ctrl & 4) ? 32 : 1)) & 'h7FFF;
            end
        end else begin
            case (sel)
                0: begin m_ctrl = d & 'hFF; m_t = (m_t & ~'hC00) | ((d & 3) << 10); end
                1: m_mask = d & 'hFF;
                5: begin
                    if (m_tog == 0) begin
                        m_fx = d & 7; m_t = (m_t & ~'h1F) | ((d >> 3) & 'h1F);
                    end else begin
                        m_t = (m_t & ~'h73E0) | ((d & 7) << 12) | (((d >> 3) & 'h1F) << 5);
                    end
                    m_tog ^= 1;
                end
                6: begin
                    if (m_tog == 0) m_t = (m_t & 'hFF) | ((d & 'h3F) << 8);
                    else begin m_t = (m_t & 'h7F00) | (d & 'hFF); m_v = m_t; end
                    m_tog ^= 1;
                end
                7: begin
                    chk(req, int'(lookup(old_v & 'h3FFF)), d & 'hFF);
                    m_v = (m_v + ((m_ctrl & 4) ? 32 : 1)) & 'h7FFF;
                end
                default: ;
            endcase
        end
    endtask

    task automatic idle(input bit vb);
        @(negedge clk);
        cs = 1'b0; vblank_set = vb;
        @(posedge clk); #1;
        if (vb) m_vbl = 1;
        vblank_set = 1'b0;
    endtask

    task automatic summary;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
            summary();
        end
    end

    initial begin
        int seed;
        m_ctrl = 0; m_mask = 0; m_vbl = 0; m_buf = 0;
        m_v = 0; m_t = 0; m_fx = 0; m_tog = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state seen at the ports
        chk("R1 v", int'(v_out), 0);
        chk("R1 t", int'(t_out), 0);
        chk("R1 fine_x", int'(fine_x), 0);
        chk("R1 ctrl", int'(ctrl_out), 0);
        chk("R1 mask", int'(mask_out), 0);
        op(1, 2, 0, 0, "R1 status");
        op(1, 7, 0, 0, "R1 buffer");
        // R2
        op(0, 0, 'h03, 0, "R2");
        op(0, 1, 'h1E, 0, "R2");
        chk("R2 t page", int'(t_out[11:10]), 3);
        // R3
        op(0, 5, 'h7D, 0, "R3");
        op(0, 5, 'h5E, 0, "R3");
        chk("R3 fine_x lit", int'(fine_x), 5);
        // R4 and R8
        op(0, 6, 'hFF, 0, "R4");
        chk("R4 bit14 clear", int'(t_out[14]), 0);
        op(0, 6, 'h10, 0, "R4");
        chk("R4 v lit", int'(v_out), 'h3F10);
        op(1, 7, 0, 0, "R8");
        op(1, 7, 0, 0, "R8");
        // R5
        op(0, 6, 'h21, 0, "R5");
        op(1, 2, 0, 0, "R5");
        op(0, 6, 'h22, 0, "R5");
        op(0, 6, 'h40, 0, "R5");
        chk("R5 v lit", int'(v_out), 'h2240);
        // R6
        op(0, 0, 'h00, 0, "R6");
        op(0, 7, 'hA1, 0, "R6");
        op(0, 7, 'hA2, 0, "R6");
        op(0, 0, 'h04, 0, "R6");
        op(0, 7, 'hB1, 0, "R6");
        op(0, 7, 'hB2, 0, "R6");
        op(0, 0, 'h00, 0, "R6");
        op(0, 6, 'h3F, 0, "R6");
        op(0, 6, 'hFF, 0, "R6");
        op(0, 7, 'hC3, 0, "R6");
        chk("R6 carry into fine Y", int'(v_out), 'h4000);
        // R7
        op(0, 6, 'h22, 0, "R7");
        op(0, 6, 'h40, 0, "R7");
        op(1, 7, 0, 0, "R7");
        op(1, 7, 0, 0, "R7");
        op(1, 7, 0, 0, "R7");
        // R9
        idle(1);
        op(1, 2, 0, 0, "R9");
        op(1, 2, 0, 0, "R9");
        op(1, 2, 0, 1, "R9");
        op(1, 2, 0, 0, "R9");
        // R10
        op(0, 2, 'h80, 0, "R10");
        op(0, 3, 'h55, 0, "R10");
        op(0, 4, 'h66, 0, "R10");
        op(1, 2, 0, 0, "R10");
        op(0, 6, 'h21, 0, "R10");
        op(1, 0, 0, 0, "R10");
        op(1, 5, 0, 0, "R10");
        op(1, 6, 0, 0, "R10");
        op(0, 6, 'h08, 0, "R10");
        chk("R10 v lit", int'(v_out), 'h2108);
        // mixed traffic against the model
        seed = 7;
        for (int i = 0; i < 300; i++) begin
            int s, d;
            bit r;
            seed = (seed * 1103515245 + 12345) & 'h7FFFFFFF;
            s = (seed >> 8) & 7;
            r = (seed >> 12) & 1;
            d = (seed >> 16) & 'hFF;
            op(r, s, d, ((seed >> 24) & 7) == 0, req_of(s, r));
        end
        summary();
    end

endmodule